// File: doc/BRIEF.md
# Split-Address Early-Indexed Cache Bank

This block is one bank of a large set-associative cache. Each read reaches it as two messages on two separate channels. A narrow, fast message comes first. It carries the set index, the bank identifier and a 3-bit request tag. On that message alone the bank starts reading every way of the set, both tags and lines. A wider, slower message follows with the remaining address bits, which here means the full tag. When both halves of a request are present, the tag is compared against all ways of the buffered set, and one response goes back to the controller.

Matching runs on the 3-bit request tag, so up to eight reads can be in flight at once, each in its own slot. Fill and replacement are outside this block. The resident contents come from a fixed formula, so every lookup has a known answer.

Top module: `early_index_bank`

## Requirements
- R1: After reset, or after a reset applied while requests are pending, `rsp_valid_o` is 0. No request accepted before the reset ever produces a response.
- R2: The fast message uses these fields: bits [9:0] set index, of which the low SET_W bits select the set; bits [15:10] bank identifier; bits [18:16] request tag. Bits [23:19] are reserved and have no effect on the response.
- R3: A fast message whose bank identifier differs from BANK_ID (default 6'h15) starts no read. A slow message with the same request tag then produces no response until a matching fast message arrives.
- R4: If the slow message arrives no later than the edge at which the set read completes, the response is visible RD_LAT+1 cycles after the edge that accepted the fast message. Default RD_LAT is 3, so that is 4 cycles.
- R5: If the slow message arrives after the set read has completed, the response is visible one cycle after the edge that accepted the slow message.
- R6: On a tag match, the response has `rsp_hit_o`=1, the request tag of the pair, the matching way index and that way's line.
- R7: When no way matches, the response has `rsp_hit_o`=0, the request tag of the pair, and a line of all zeros.
- R8: Fast and slow messages are paired by request tag. Eight requests can be outstanding at once, and they complete in the order their slow messages arrive.
- R9: At most one response is issued per cycle. When several pairs become complete at the same edge, the lowest request tag is answered first and the others follow in later cycles.
- R10: Each paired request produces exactly one response, and its slot is then free.
- R11: Way w of set s holds tag ((s*WAYS + w) XOR TAG_SALT), truncated to TAG_W bits (default salt 12'h5A3). Its line is (tag << 16) | (s << 8) | w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fast_valid_i | input | 1 | Fast message present this cycle |
| fast_msg_i | input | 24 | Fast message: set index, bank id, request tag, reserved |
| late_valid_i | input | 1 | Slow message present this cycle |
| late_id_i | input | 3 | Request tag of the slow message |
| late_tag_i | input | TAG_W | Remaining address bits (full tag) |
| rsp_valid_o | output | 1 | Response present, one-cycle pulse |
| rsp_hit_o | output | 1 | Tag matched |
| rsp_id_o | output | 3 | Request tag of the response |
| rsp_way_o | output | WAY_W | Matching way |
| rsp_line_o | output | LINE_W | Line data, zero on a miss |

## Verification
If the slot table has the wrong state, the ports show it within one cycle of the second half arriving. The symptom is a response with a wrong request tag, a line taken from another set, or a pair that never answers at all. Slots that stay marked after reset or after a response show up as spurious or repeated responses. A read pipeline that is too short or too long shifts the response by a whole cycle, which the latency checks catch directly. A priority fault shows up as a swapped order when two pairs complete on the same edge.

// File: rtl/ebank_pkg.sv
package ebank_pkg;
  localparam int FAST_W   = 24;
  localparam int IDX_LSB  = 0;
  localparam int IDX_W    = 10;
  localparam int BANK_LSB = 10;
  localparam int BANK_W   = 6;
  localparam int RID_LSB  = 16;
  localparam int RID_W    = 3;
  localparam int SLOTS    = 1 << RID_W;

  typedef logic [RID_W-1:0] rid_t;
endpackage

// File: rtl/ebank_resident.sv
module ebank_resident #(
  parameter int SET_W    = 4,
  parameter int WAYS     = 8,
  parameter int TAG_W    = 12,
  parameter int LINE_W   = 32,
  parameter int TAG_SALT = 12'h5A3
) (
  input  logic [SET_W-1:0]  set_i,
  output logic [TAG_W-1:0]  tags_o  [WAYS],
  output logic [LINE_W-1:0] lines_o [WAYS]
);
  // contents are fixed; fills live outside this bank
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      logic [31:0] t;
      t = ((32'(set_i) * 32'(WAYS)) + 32'(w)) ^ 32'(TAG_SALT);
      tags_o[w]  = TAG_W'(t);
      lines_o[w] = LINE_W'((32'(TAG_W'(t)) << 16) | (32'(set_i) << 8) | 32'(w));
    end
  end
endmodule

// File: rtl/ebank_read_pipe.sv
module ebank_read_pipe
  import ebank_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 32,
  parameter int RD_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  rid_t              id_i,
  input  logic [TAG_W-1:0]  tags_i  [WAYS],
  input  logic [LINE_W-1:0] lines_i [WAYS],
  output logic              done_o,
  output rid_t              id_o,
  output logic [TAG_W-1:0]  tags_o  [WAYS],
  output logic [LINE_W-1:0] lines_o [WAYS]
);
  logic              vld_q [RD_LAT];
  rid_t              id_q  [RD_LAT];
  logic [TAG_W-1:0]  tg_q  [RD_LAT][WAYS];
  logic [LINE_W-1:0] ln_q  [RD_LAT][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < RD_LAT; k++) vld_q[k] <= 1'b0;
    end else begin
      vld_q[0] <= start_i;
      for (int k = 1; k < RD_LAT; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  always_ff @(posedge clk_i) begin
    id_q[0] <= id_i;
    tg_q[0] <= tags_i;
    ln_q[0] <= lines_i;
    for (int k = 1; k < RD_LAT; k++) begin
      id_q[k] <= id_q[k-1];
      tg_q[k] <= tg_q[k-1];
      ln_q[k] <= ln_q[k-1];
    end
  end

  assign done_o  = vld_q[RD_LAT-1];
  assign id_o    = id_q[RD_LAT-1];
  assign tags_o  = tg_q[RD_LAT-1];
  assign lines_o = ln_q[RD_LAT-1];
endmodule

// File: rtl/ebank_pair_table.sv
module ebank_pair_table
  import ebank_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rid_t              done_id_i,
  input  logic [TAG_W-1:0]  done_tags_i  [WAYS],
  input  logic [LINE_W-1:0] done_lines_i [WAYS],
  input  logic              late_valid_i,
  input  rid_t              late_id_i,
  input  logic [TAG_W-1:0]  late_tag_i,
  output logic              sel_valid_o,
  output rid_t              sel_id_o,
  output logic [TAG_W-1:0]  sel_want_o,
  output logic [TAG_W-1:0]  sel_tags_o  [WAYS],
  output logic [LINE_W-1:0] sel_lines_o [WAYS]
);
  logic [SLOTS-1:0]  set_rdy_q, tag_rdy_q, complete;
  logic [TAG_W-1:0]  want_q [SLOTS];
  logic [TAG_W-1:0]  btag_q [SLOTS][WAYS];
  logic [LINE_W-1:0] bln_q  [SLOTS][WAYS];

  assign complete = set_rdy_q & tag_rdy_q;

  // lowest request tag wins
  always_comb begin
    sel_valid_o = 1'b0;
    sel_id_o    = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (complete[i]) begin
        sel_valid_o = 1'b1;
        sel_id_o    = rid_t'(i);
      end
    end
  end

  assign sel_want_o  = want_q[sel_id_o];
  assign sel_tags_o  = btag_q[sel_id_o];
  assign sel_lines_o = bln_q[sel_id_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_rdy_q <= '0;
      tag_rdy_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (sel_valid_o && sel_id_o == rid_t'(i)) begin
          set_rdy_q[i] <= 1'b0;
          tag_rdy_q[i] <= 1'b0;
        end
        if (done_i && done_id_i == rid_t'(i))       set_rdy_q[i] <= 1'b1;
        if (late_valid_i && late_id_i == rid_t'(i)) tag_rdy_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (done_i) begin
      btag_q[done_id_i] <= done_tags_i;
      bln_q[done_id_i]  <= done_lines_i;
    end
    if (late_valid_i) want_q[late_id_i] <= late_tag_i;
  end
endmodule

// File: rtl/ebank_tag_match.sv
module ebank_tag_match #(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0]  want_i,
  input  logic [TAG_W-1:0]  tags_i  [WAYS],
  input  logic [LINE_W-1:0] lines_i [WAYS],
  output logic              hit_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [LINE_W-1:0] line_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = (tags_i[w] == want_i);
  end

  always_comb begin
    hit_o  = |eq;
    way_o  = '0;
    line_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        way_o  = WAY_W'(w);
        line_o = lines_i[w];
      end
    end
  end
endmodule

// File: rtl/early_index_bank.sv
module early_index_bank
  import ebank_pkg::*;
#(
  parameter int          SET_W    = 4,
  parameter int          WAYS     = 8,
  parameter int          TAG_W    = 12,
  parameter int          LINE_W   = 32,
  parameter int          RD_LAT   = 3,
  parameter logic [5:0]  BANK_ID  = 6'h15,
  parameter int          TAG_SALT = 12'h5A3,
  localparam int         WAY_W    = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_valid_i,
  input  logic [23:0]       fast_msg_i,
  input  logic              late_valid_i,
  input  logic [2:0]        late_id_i,
  input  logic [TAG_W-1:0]  late_tag_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [2:0]        rsp_id_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [LINE_W-1:0] rsp_line_o
);
  logic [SET_W-1:0]  set_idx;
  logic [BANK_W-1:0] bank_fld;
  rid_t              fast_id;
  logic              rd_start;

  assign set_idx  = fast_msg_i[IDX_LSB +: SET_W];
  assign bank_fld = fast_msg_i[BANK_LSB +: BANK_W];
  assign fast_id  = fast_msg_i[RID_LSB +: RID_W];
  assign rd_start = fast_valid_i && (bank_fld == BANK_ID);

  logic [TAG_W-1:0]  arr_tags  [WAYS];
  logic [LINE_W-1:0] arr_lines [WAYS];

  ebank_resident #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W),
                   .TAG_SALT(TAG_SALT)) u_res (
    .set_i(set_idx), .tags_o(arr_tags), .lines_o(arr_lines));

  logic              rd_done;
  rid_t              rd_id;
  logic [TAG_W-1:0]  rd_tags  [WAYS];
  logic [LINE_W-1:0] rd_lines [WAYS];

  ebank_read_pipe #(.WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W), .RD_LAT(RD_LAT)) u_pipe (
    .clk_i, .rst_ni, .start_i(rd_start), .id_i(fast_id),
    .tags_i(arr_tags), .lines_i(arr_lines),
    .done_o(rd_done), .id_o(rd_id), .tags_o(rd_tags), .lines_o(rd_lines));

  logic              sel_valid;
  rid_t              sel_id;
  logic [TAG_W-1:0]  sel_want;
  logic [TAG_W-1:0]  sel_tags  [WAYS];
  logic [LINE_W-1:0] sel_lines [WAYS];

  ebank_pair_table #(.WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_tab (
    .clk_i, .rst_ni,
    .done_i(rd_done), .done_id_i(rd_id), .done_tags_i(rd_tags), .done_lines_i(rd_lines),
    .late_valid_i, .late_id_i(rid_t'(late_id_i)), .late_tag_i,
    .sel_valid_o(sel_valid), .sel_id_o(sel_id), .sel_want_o(sel_want),
    .sel_tags_o(sel_tags), .sel_lines_o(sel_lines));

  logic              m_hit;
  logic [WAY_W-1:0]  m_way;
  logic [LINE_W-1:0] m_line;

  ebank_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_match (
    .want_i(sel_want), .tags_i(sel_tags), .lines_i(sel_lines),
    .hit_o(m_hit), .way_o(m_way), .line_o(m_line));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_id_o    <= '0;
      rsp_way_o   <= '0;
      rsp_line_o  <= '0;
    end else begin
      rsp_valid_o <= sel_valid;
      rsp_hit_o   <= sel_valid && m_hit;
      rsp_id_o    <= sel_id;
      rsp_way_o   <= m_way;
      rsp_line_o  <= m_line;
    end
  end
endmodule

// File: rtl/early_index_bank_chk.sv
module early_index_bank_chk #(
  parameter int         LINE_W  = 32,
  parameter int         WAY_W   = 3,
  parameter logic [5:0] BANK_ID = 6'h15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fast_valid_i,
  input logic [23:0]       fast_msg_i,
  input logic              late_valid_i,
  input logic [2:0]        late_id_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [2:0]        rsp_id_o,
  input logic [WAY_W-1:0]  rsp_way_o,
  input logic [LINE_W-1:0] rsp_line_o
);
  logic [7:0] fast_seen_q, late_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_seen_q <= '0;
      late_seen_q <= '0;
    end else begin
      if (rsp_valid_o) begin
        fast_seen_q[rsp_id_o] <= 1'b0;
        late_seen_q[rsp_id_o] <= 1'b0;
      end
      if (fast_valid_i && fast_msg_i[15:10] == BANK_ID) fast_seen_q[fast_msg_i[18:16]] <= 1'b1;
      if (late_valid_i) late_seen_q[late_id_i] <= 1'b1;
    end
  end

  AST_RSP_NEEDS_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> fast_seen_q[rsp_id_o]); // R3

  AST_RSP_NEEDS_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> late_seen_q[rsp_id_o]); // R8

  AST_MISS_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_line_o == '0)); // R7

  AST_HIT_WAY_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> (rsp_line_o[7:0] == 8'(rsp_way_o))); // R11

  AST_NO_REPEAT_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !(rsp_valid_o && rsp_id_o == $past(rsp_id_o))); // R10
endmodule

bind early_index_bank early_index_bank_chk #(.LINE_W(LINE_W), .WAY_W(WAY_W), .BANK_ID(BANK_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fast_valid_i(fast_valid_i), .fast_msg_i(fast_msg_i),
  .late_valid_i(late_valid_i), .late_id_i(late_id_i), .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o(rsp_hit_o), .rsp_id_o(rsp_id_o), .rsp_way_o(rsp_way_o), .rsp_line_o(rsp_line_o));

// File: tb/early_index_bank_bench.sv
`timescale 1ns/1ps
module early_index_bank_bench;
  localparam logic [5:0] MY_BANK = 6'h15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fast_valid_i = 1'b0;
  logic [23:0] fast_msg_i = '0;
  logic        late_valid_i = 1'b0;
  logic [2:0]  late_id_i = '0;
  logic [11:0] late_tag_i = '0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [2:0]  rsp_id_o, rsp_way_o;
  logic [31:0] rsp_line_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  early_index_bank u_early_index_bank (
    .clk_i, .rst_ni, .fast_valid_i, .fast_msg_i, .late_valid_i, .late_id_i, .late_tag_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_id_o, .rsp_way_o, .rsp_line_o);

  function automatic logic [11:0] tag_of(int s, int w);
    return 12'((s * 8 + w) ^ 12'h5A3);
  endfunction

  function automatic logic [31:0] line_of(int s, int w);
    return {4'h0, tag_of(s, w), 8'(s), 8'(w)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  // drive one cycle of messages; returns on the negedge after the edge
  task automatic drive(logic fv, logic [9:0] idx, logic [5:0] bank, logic [2:0] id,
                       logic [4:0] rsvd, logic lv, logic [2:0] lid, logic [11:0] ltag);
    fast_valid_i = fv;
    fast_msg_i   = {rsvd, id, bank, idx};
    late_valid_i = lv;
    late_id_i    = lid;
    late_tag_i   = ltag;
    @(posedge clk_i); @(negedge clk_i);
    fast_valid_i = 1'b0;
    late_valid_i = 1'b0;
  endtask

  task automatic wait_rsp(int lim, output int cyc);
    cyc = 0;
    while (!rsp_valid_o && cyc < lim) begin tick(1); cyc++; end
  endtask

  task automatic check_rsp(string req, logic [2:0] id, logic hit, int s, int w);
    check({req, " valid"}, 64'(rsp_valid_o), 64'd1);
    check({req, " id"}, 64'(rsp_id_o), 64'(id));
    check({req, " hit"}, 64'(rsp_hit_o), 64'(hit));
    if (hit) begin
      check({req, " way"}, 64'(rsp_way_o), 64'(w));
      check({req, " line"}, 64'(rsp_line_o), 64'(line_of(s, w)));
    end else begin
      check({req, " line zero"}, 64'(rsp_line_o), 64'd0);
    end
  endtask

  typedef struct packed {
    logic [9:0] idx;
    logic [2:0] id;
    logic [2:0] way;
    logic       hit;
    logic [4:0] rsvd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{10'd3,   3'd1, 3'd5, 1'b1, 5'h00},
    '{10'd0,   3'd0, 3'd0, 1'b1, 5'h00},
    '{10'd15,  3'd7, 3'd7, 1'b1, 5'h1F},
    '{10'd9,   3'd4, 3'd2, 1'b0, 5'h00},
    '{10'd27,  3'd2, 3'd6, 1'b1, 5'h00},
    '{10'd6,   3'd3, 3'd3, 1'b1, 5'h15},
    '{10'd12,  3'd5, 3'd1, 1'b0, 5'h00},
    '{10'd1,   3'd6, 3'd4, 1'b1, 5'h0A}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int cyc;
    tick(3);
    check("R1 reset rsp_valid", 64'(rsp_valid_o), 64'd0);
    rst_ni = 1'b1;
    tick(2);
    check("R1 idle after reset", 64'(rsp_valid_o), 64'd0);

    // table: fast and slow halves in the same cycle
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      int s;
      logic [11:0] t;
      v = VECS[i];
      s = int'(v.idx) % 16;
      t = v.hit ? tag_of(s, int'(v.way)) : tag_of((s + 1) % 16, int'(v.way));
      drive(1'b1, v.idx, MY_BANK, v.id, v.rsvd, 1'b1, v.id, t);
      wait_rsp(10, cyc);
      check("R4 latency early pair", 64'(cyc), 64'd4);
      check_rsp(v.hit ? "R6 R2 hit" : "R7 miss", v.id, v.hit, s, int'(v.way));
      tick(1);
    end

    // R5: slow half long after the read
    drive(1'b1, 10'd4, MY_BANK, 3'd3, 5'h0, 1'b0, 3'd0, 12'h0);
    tick(10);
    drive(1'b0, 10'd0, 6'h0, 3'd0, 5'h0, 1'b1, 3'd3, tag_of(4, 6));
    wait_rsp(10, cyc);
    check("R5 latency late pair", 64'(cyc), 64'd1);
    check_rsp("R5 hit", 3'd3, 1'b1, 4, 6);
    tick(1);

    // R3: wrong bank starts nothing; later correct fast pairs with stored slow half
    drive(1'b1, 10'd5, 6'h02, 3'd2, 5'h0, 1'b0, 3'd0, 12'h0);
    drive(1'b0, 10'd0, 6'h0, 3'd0, 5'h0, 1'b1, 3'd2, tag_of(5, 1));
    wait_rsp(12, cyc);
    check("R3 no response for foreign bank", 64'(rsp_valid_o), 64'd0);
    drive(1'b1, 10'd5, MY_BANK, 3'd2, 5'h0, 1'b0, 3'd0, 12'h0);
    wait_rsp(10, cyc);
    check("R3 R4 latency after own fast", 64'(cyc), 64'd4);
    check_rsp("R3 own bank hit", 3'd2, 1'b1, 5, 1);
    tick(1);

    // R9: two pairs complete on the same edge
    drive(1'b1, 10'd7, MY_BANK, 3'd2, 5'h0, 1'b0, 3'd0, 12'h0);
    drive(1'b1, 10'd8, MY_BANK, 3'd5, 5'h0, 1'b1, 3'd5, tag_of(8, 0));
    tick(2);
    drive(1'b0, 10'd0, 6'h0, 3'd0, 5'h0, 1'b1, 3'd2, tag_of(7, 3));
    check("R9 nothing before priority pair", 64'(rsp_valid_o), 64'd0);
    tick(1);
    check_rsp("R9 lowest tag first", 3'd2, 1'b1, 7, 3);
    tick(1);
    check_rsp("R9 second next cycle", 3'd5, 1'b1, 8, 0);
    tick(1);
    check("R10 no extra response", 64'(rsp_valid_o), 64'd0);

    // R8: eight outstanding, answered in reverse order
    for (int i = 0; i < 8; i++)
      drive(1'b1, 10'(i + 2), MY_BANK, 3'(i), 5'h0, 1'b0, 3'd0, 12'h0);
    tick(4);
    for (int i = 7; i >= 0; i--) begin
      drive(1'b0, 10'd0, 6'h0, 3'd0, 5'h0, 1'b1, 3'(i), tag_of(i + 2, i ^ 3));
      tick(1);
      check_rsp("R8 out of order", 3'(i), 1'b1, i + 2, i ^ 3);
    end
    tick(6);
    check("R10 all slots drained", 64'(rsp_valid_o), 64'd0);

    // R1: reset drops a pending request
    drive(1'b1, 10'd10, MY_BANK, 3'd1, 5'h0, 1'b0, 3'd0, 12'h0);
    rst_ni = 1'b0;
    tick(1);
    check("R1 reset output", 64'(rsp_valid_o), 64'd0);
    rst_ni = 1'b1;
    tick(5);
    drive(1'b0, 10'd0, 6'h0, 3'd0, 5'h0, 1'b1, 3'd1, tag_of(10, 2));
    wait_rsp(10, cyc);
    check("R1 pending dropped by reset", 64'(rsp_valid_o), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule